// File: doc/BRIEF.md
# Dejitter Bit-Level Elastic Store

This block is the small elastic buffer at the centre of a jitter attenuator. A line clock that may be gapped or jittery writes bit pairs into it. Each pair holds one positive-rail bit and one negative-rail bit. A separately generated smoothed clock reads the pairs back out, one pair per enabled cycle. The smoothed clock is also passed straight through as an output, so downstream logic gets the data together with the clock that times it.

The buffer has no flow control. Instead it reports a fill level and a registered near-full flag in the read domain, and an external digital loop uses these to speed up or slow down the smoothed clock. A static mode input selects a usable depth of 16 or 32 pairs. At reset, and whenever the depth selection changes, the read pointer is set half a depth behind the write pointer, so the buffer starts centred. If the writer overruns the reader, or a read is requested from an empty buffer, the block records a slip and re-centres.

Top module: `dj_elastic_store`

## Requirements
- R1: While the read-side reset is low, `rd_pos`, `rd_neg`, `fill_level`, `limit_flag`, `slip` and `slip_seen` are all 0. After reset the buffer reports a fill of half the selected depth: 8 when `deep_mode`=0 and 16 when `deep_mode`=1. Every pair in that centring region reads out as 0/0.
- R2: Each write-clock edge with `wr_en`=1 stores (`wr_pos`, `wr_neg`) and raises the read-side fill by one. The new value shows on `fill_level` within four read-clock cycles.
- R3: A read-clock edge with `rd_en`=1 and a non-zero fill presents the oldest stored pair on `rd_pos`/`rd_neg` after that edge, and lowers the fill by one. Pairs come out in the order they were written.
- R4: `limit_flag` is registered. It is 1 while the fill is at least the selected depth minus 2 (14 or 32-2=30) and 0 once the fill drops below that level.
- R5: `deep_mode`=0 selects a usable depth of 16 pairs; `deep_mode`=1 selects 32 pairs.
- R6: A read request while the fill is 0 is an underrun. The outputs keep the last pair read, `slip` pulses for one cycle, `slip_seen` sets, and the read pointer moves to half the depth behind the writer, so the next read returns the pair written that many places back.
- R7: A fill above the selected depth is an overrun. `slip` pulses, `slip_seen` sets, and the reader jumps to half the depth behind the writer, so the oldest pairs are skipped.
- R8: A change of `deep_mode` without reset re-centres the buffer to half of the new depth and does not set `slip_seen`.
- R9: Once set, `slip_seen` stays at 1 until a read-side reset.
- R10: `smooth_clk_out` follows `rd_clk`.
- R11: On a read-clock edge with `rd_en`=0, `rd_pos` and `rd_neg` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Incoming line clock, may be gapped |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Store the pair on this write edge |
| wr_pos | input | 1 | Positive-rail input bit |
| wr_neg | input | 1 | Negative-rail input bit |
| rd_clk | input | 1 | Smoothed read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Take one pair on this read edge |
| deep_mode | input | 1 | 0: 16-pair depth, 1: 32-pair depth |
| rd_pos | output | 1 | Positive-rail output bit |
| rd_neg | output | 1 | Negative-rail output bit |
| smooth_clk_out | output | 1 | Copy of the smoothed clock |
| fill_level | output | 6 | Registered fill count in read domain |
| limit_flag | output | 1 | Registered near-full indication |
| slip | output | 1 | One-cycle pulse on overrun or underrun |
| slip_seen | output | 1 | Sticky slip indication |

## Verification
The interesting coincidence is a read request arriving in the same read cycle that the store is found empty. Both the normal read path and the underrun re-centring then compete for the read pointer and the output register. The bench writes eight pairs, drains all the stored pairs, and then issues one more read. It judges that cycle by checking three things: the output still carries the last pair, the slip pulse and sticky bit appear on that edge, and the fill comes back to half depth with the next read returning the pair written eight places earlier. Overrun is provoked by writing past full with no reads, and is judged by the new fill and by which pair the next read returns.

// File: rtl/dj_pkg.sv
// Shared types for the dejitter elastic store.
// Assumes: one entry holds a single positive/negative rail bit pair.
package dj_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
    } dj_pair_t;

endpackage

// File: rtl/dj_sync.sv
// Multi-bit synchroniser chain into a destination clock.
// Assumes: the source changes at most one bit per source cycle (Gray coded),
// or is quasi-static, so sampling any bit skew is harmless.
module dj_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first capture flop from the foreign domain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            // later settling flops
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/dj_wr_port.sv
// Write side: pair storage, binary write pointer and its Gray copy.
// Assumes: DEPTH is a power of two, equal to 2**ADDR_W; the writer never
// stalls, so an overrun simply overwrites the oldest entries.
module dj_wr_port
    import dj_pkg::*;
#(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  dj_pair_t          wr_pair,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  wgray,
    output dj_pair_t          rd_pair
);

    dj_pair_t          store [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  wptr_nxt;

    assign wptr_nxt = wptr + PTR_W'(1);

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // one storage entry, loaded when the write pointer addresses it
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[e] <= '0;
            else if (wr_en && (wptr[ADDR_W-1:0] == ADDR_W'(e)))
                store[e] <= wr_pair;
        end
    end

    // advance the write pointer and register its Gray image together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // read mux seen by the read domain; addressed entries are settled
    assign rd_pair = store[rd_addr];

endmodule

// File: rtl/dj_rd_port.sv
// Read side: read pointer, fill computation, near-full flag, slip handling
// and centring. Assumes wgray_sync and deep_sel are already synchronised
// into this clock domain.
module dj_rd_port
    import dj_pkg::*;
#(
    parameter int unsigned SHALLOW_DEPTH = 16,
    parameter int unsigned DEEP_DEPTH    = 32,
    parameter int unsigned LIMIT_MARGIN  = 2,
    parameter int unsigned ADDR_W        = 5,
    parameter int unsigned PTR_W         = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              deep_sel,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  dj_pair_t          mem_pair,
    output logic [ADDR_W-1:0] rd_addr,
    output dj_pair_t          out_pair,
    output logic [PTR_W-1:0]  fill_level,
    output logic              limit_flag,
    output logic              slip,
    output logic              slip_seen
);

    localparam logic [PTR_W-1:0] SH_P    = PTR_W'(SHALLOW_DEPTH);
    localparam logic [PTR_W-1:0] DP_P    = PTR_W'(DEEP_DEPTH);
    localparam logic [PTR_W-1:0] SH_HALF = PTR_W'(SHALLOW_DEPTH / 2);
    localparam logic [PTR_W-1:0] DP_HALF = PTR_W'(DEEP_DEPTH / 2);
    localparam logic [PTR_W-1:0] MARGIN  = PTR_W'(LIMIT_MARGIN);

    function automatic logic [PTR_W-1:0] gray_to_bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] rptr;
    logic [PTR_W-1:0] fill;
    logic [PTR_W-1:0] depth_cur;
    logic [PTR_W-1:0] half_new;
    logic             depth_q;
    logic             mode_change;
    logic             overrun;
    logic             underrun;
    logic             slip_evt;
    logic             take;

    // decode writer position, fill and the competing pointer events
    always_comb begin
        wbin        = gray_to_bin(wgray_sync);
        fill        = wbin - rptr;
        depth_cur   = depth_q ? DP_P : SH_P;
        half_new    = deep_sel ? DP_HALF : SH_HALF;
        mode_change = (deep_sel != depth_q);
        overrun     = (fill > depth_cur);
        underrun    = rd_en && (fill == '0);
        slip_evt    = !mode_change && (overrun || underrun);
        take        = rd_en && !mode_change && !overrun && !underrun;
    end

    assign rd_addr = rptr[ADDR_W-1:0];

    // read pointer: centring has priority over slips, slips over reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0 - SH_HALF;
            depth_q <= 1'b0;
        end else if (mode_change) begin
            rptr    <= wbin - half_new;
            depth_q <= deep_sel;
        end else if (overrun || underrun) begin
            rptr    <= wbin - half_new;
        end else if (take) begin
            rptr    <= rptr + PTR_W'(1);
        end
    end

    // output pair register; holds on idle, slip and centring cycles
    always_ff @(posedge clk) begin
        if (!rst_n)    out_pair <= '0;
        else if (take) out_pair <= mem_pair;
    end

    // slip pulse and its sticky record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slip      <= 1'b0;
            slip_seen <= 1'b0;
        end else begin
            slip      <= slip_evt;
            slip_seen <= slip_seen | slip_evt;
        end
    end

    // fill level and near-full flag exported to the smoothing loop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_level <= '0;
            limit_flag <= 1'b0;
        end else begin
            fill_level <= fill;
            limit_flag <= (fill >= (depth_cur - MARGIN));
        end
    end

endmodule

// File: rtl/dj_elastic_store.sv
// Top of the dejitter elastic store: dual-rail one-bit pairs written on the
// line clock, read on the smoothed clock. Assumes DEEP_DEPTH is a power of
// two and SHALLOW_DEPTH is even and not larger than DEEP_DEPTH.
module dj_elastic_store
    import dj_pkg::*;
#(
    parameter  int unsigned SHALLOW_DEPTH = 16,
    parameter  int unsigned DEEP_DEPTH    = 32,
    parameter  int unsigned LIMIT_MARGIN  = 2,
    parameter  int unsigned SYNC_STAGES   = 2,
    localparam int unsigned ADDR_W        = $clog2(DEEP_DEPTH),
    localparam int unsigned PTR_W         = ADDR_W + 1
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic             wr_pos,
    input  logic             wr_neg,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_en,
    input  logic             deep_mode,
    output logic             rd_pos,
    output logic             rd_neg,
    output logic             smooth_clk_out,
    output logic [PTR_W-1:0] fill_level,
    output logic             limit_flag,
    output logic             slip,
    output logic             slip_seen
);

    dj_pair_t          in_pair;
    dj_pair_t          mem_pair;
    dj_pair_t          out_pair;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  wgray_sync;
    logic [ADDR_W-1:0] rd_addr;
    logic              deep_sync;

    assign in_pair.pos    = wr_pos;
    assign in_pair.neg    = wr_neg;
    assign rd_pos         = out_pair.pos;
    assign rd_neg         = out_pair.neg;
    assign smooth_clk_out = rd_clk;

    dj_wr_port #(
        .DEPTH  (DEEP_DEPTH),
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W)
    ) u_wr (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .wr_en   (wr_en),
        .wr_pair (in_pair),
        .rd_addr (rd_addr),
        .wgray   (wgray),
        .rd_pair (mem_pair)
    );

    dj_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_sync)
    );

    dj_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_mode_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (deep_mode),
        .q     (deep_sync)
    );

    dj_rd_port #(
        .SHALLOW_DEPTH (SHALLOW_DEPTH),
        .DEEP_DEPTH    (DEEP_DEPTH),
        .LIMIT_MARGIN  (LIMIT_MARGIN),
        .ADDR_W        (ADDR_W),
        .PTR_W         (PTR_W)
    ) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .rd_en      (rd_en),
        .deep_sel   (deep_sync),
        .wgray_sync (wgray_sync),
        .mem_pair   (mem_pair),
        .rd_addr    (rd_addr),
        .out_pair   (out_pair),
        .fill_level (fill_level),
        .limit_flag (limit_flag),
        .slip       (slip),
        .slip_seen  (slip_seen)
    );

endmodule

// File: rtl/dj_elastic_store_chk.sv
// Read-domain property checker for dj_elastic_store, attached by bind.
// Assumes the read-side reset is synchronous and active low.
module dj_elastic_store_chk #(
    parameter int unsigned SHALLOW_DEPTH = 16,
    parameter int unsigned DEEP_DEPTH    = 32,
    parameter int unsigned LIMIT_MARGIN  = 2,
    parameter int unsigned PTR_W         = 6
) (
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             rd_en,
    input logic             rd_pos,
    input logic             rd_neg,
    input logic [PTR_W-1:0] fill_level,
    input logic             limit_flag,
    input logic             slip,
    input logic             slip_seen
);

    localparam logic [PTR_W-1:0] LOW_THR  = PTR_W'(SHALLOW_DEPTH - LIMIT_MARGIN);
    localparam logic [PTR_W-1:0] HIGH_THR = PTR_W'(DEEP_DEPTH - LIMIT_MARGIN);
    localparam logic [PTR_W-1:0] MAX_FILL = PTR_W'(DEEP_DEPTH + 1);

    assert_limit_low_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fill_level < LOW_THR) |-> !limit_flag);

    assert_limit_high_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fill_level >= HIGH_THR) |-> limit_flag);

    assert_slip_marks_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        slip |-> slip_seen);

    assert_slip_single_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        slip |=> !slip);

    assert_fill_bound_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        fill_level <= MAX_FILL);

    assert_sticky_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        slip_seen |=> slip_seen);

    assert_hold_R11: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_en |=> ($stable(rd_pos) && $stable(rd_neg)));

endmodule

bind dj_elastic_store dj_elastic_store_chk #(
    .SHALLOW_DEPTH (SHALLOW_DEPTH),
    .DEEP_DEPTH    (DEEP_DEPTH),
    .LIMIT_MARGIN  (LIMIT_MARGIN),
    .PTR_W         (PTR_W)
) u_chk (
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .rd_en      (rd_en),
    .rd_pos     (rd_pos),
    .rd_neg     (rd_neg),
    .fill_level (fill_level),
    .limit_flag (limit_flag),
    .slip       (slip),
    .slip_seen  (slip_seen)
);

// File: tb/tb_dj_elastic_store.sv
// Self-checking bench: vector table of fill/limit outcomes, then directed
// tests for reset, ordering, underrun, overrun, mode change and clock copy.
module tb_dj_elastic_store;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, wr_pos, wr_neg;
    logic       rd_en, deep_mode;
    logic       rd_pos, rd_neg, smooth_clk_out;
    logic [5:0] fill_level;
    logic       limit_flag, slip, slip_seen;

    int checks   = 0;
    int failures = 0;

    localparam logic [15:0] PAT_P = 16'b0110_1001_1011_0010;
    localparam logic [15:0] PAT_N = 16'b1100_0101_0110_1001;

    // {deep_mode, writes, reads, expected fill, expected limit}
    localparam int VEC [10][5] = '{
        '{0,  0,  0,  8, 0},
        '{0,  5,  0, 13, 0},
        '{0,  6,  0, 14, 1},
        '{0,  8,  0, 16, 1},
        '{0,  8,  3, 13, 0},
        '{1,  0,  0, 16, 0},
        '{1, 13,  0, 29, 0},
        '{1, 14,  0, 30, 1},
        '{1,  4, 10, 10, 0},
        '{1, 16,  0, 32, 1}
    };

    always #2 clk = ~clk;

    dj_elastic_store dut (
        .wr_clk         (clk),
        .wr_rst_n       (rst_n),
        .wr_en          (wr_en),
        .wr_pos         (wr_pos),
        .wr_neg         (wr_neg),
        .rd_clk         (clk),
        .rd_rst_n       (rst_n),
        .rd_en          (rd_en),
        .deep_mode      (deep_mode),
        .rd_pos         (rd_pos),
        .rd_neg         (rd_neg),
        .smooth_clk_out (smooth_clk_out),
        .fill_level     (fill_level),
        .limit_flag     (limit_flag),
        .slip           (slip),
        .slip_seen      (slip_seen)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive on the falling edge, sample 1 ns after the rising edge
    task automatic cycle(input logic we, input logic wp, input logic wn, input logic re);
        @(negedge clk);
        wr_en = we; wr_pos = wp; wr_neg = wn; rd_en = re;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) cycle(1'b1, PAT_P[i%16], PAT_N[i%16], 1'b0);
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; deep_mode = mode;
        wr_en = 1'b0; wr_pos = 1'b0; wr_neg = 1'b0; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(8);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; deep_mode = 1'b0;
        wr_en = 1'b0; wr_pos = 1'b0; wr_neg = 1'b0; rd_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        // R1: quiet outputs while reset is held
        check("R1 rd_pos in reset", rd_pos, 0);
        check("R1 rd_neg in reset", rd_neg, 0);
        check("R1 fill in reset", fill_level, 0);
        check("R1 limit in reset", limit_flag, 0);
        check("R1 slip in reset", slip, 0);
        check("R1 slip_seen in reset", slip_seen, 0);

        // table walk: R2 writes, R3 reads, R4 limit, R5 depth select
        for (int v = 0; v < 10; v++) begin
            do_reset(VEC[v][0] != 0);
            write_n(VEC[v][1]);
            idle(5);
            read_n(VEC[v][2]);
            idle(5);
            check($sformatf("R2/R3/R5 fill row %0d", v), fill_level, VEC[v][3]);
            check($sformatf("R4 limit row %0d", v), limit_flag, VEC[v][4]);
        end

        // R1 centring contents, R3 order, R6 underrun on a read request
        do_reset(1'b0);
        write_n(8);
        idle(4);
        check("R2 fill after 8 writes", fill_level, 16);
        for (int i = 0; i < 8; i++) begin
            read_n(1);
            check("R1 centring pair pos", rd_pos, 0);
            check("R1 centring pair neg", rd_neg, 0);
        end
        for (int i = 0; i < 8; i++) begin
            read_n(1);
            check($sformatf("R3 order pos %0d", i), rd_pos, PAT_P[i]);
            check($sformatf("R3 order neg %0d", i), rd_neg, PAT_N[i]);
        end
        check("R6 no slip before underrun", slip_seen, 0);
        read_n(1);
        check("R6 underrun holds pos", rd_pos, PAT_P[7]);
        check("R6 underrun holds neg", rd_neg, PAT_N[7]);
        check("R6 slip pulse", slip, 1);
        check("R6 slip_seen set", slip_seen, 1);
        idle(1);
        check("R6 slip pulse ends", slip, 0);
        check("R11 idle holds pos", rd_pos, PAT_P[7]);
        idle(3);
        check("R6 recentred fill", fill_level, 8);
        read_n(1);
        check("R6 recentred read pos", rd_pos, PAT_P[0]);
        check("R6 recentred read neg", rd_neg, PAT_N[0]);
        idle(20);
        check("R9 slip_seen sticky", slip_seen, 1);
        do_reset(1'b0);
        check("R9 slip_seen cleared by reset", slip_seen, 0);

        // R7 overrun: nine writes into a 16 deep store centred at 8
        write_n(9);
        idle(6);
        check("R7 overrun slip_seen", slip_seen, 1);
        check("R7 overrun recentred fill", fill_level, 8);
        read_n(1);
        check("R7 oldest skipped pos", rd_pos, PAT_P[1]);
        check("R7 oldest skipped neg", rd_neg, PAT_N[1]);

        // R8 depth change without reset
        do_reset(1'b0);
        check("R5 shallow centre", fill_level, 8);
        @(negedge clk);
        deep_mode = 1'b1;
        idle(6);
        check("R8 deep centre after change", fill_level, 16);
        check("R8 no slip on change", slip_seen, 0);
        @(negedge clk);
        deep_mode = 1'b0;
        idle(6);
        check("R8 shallow centre after change", fill_level, 8);
        check("R8 still no slip", slip_seen, 0);

        // R10 clock copy
        @(posedge clk); #1;
        check("R10 clock copy high", smooth_clk_out, 1);
        @(negedge clk); #1;
        check("R10 clock copy low", smooth_clk_out, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule